// File: doc/BRIEF.md
# Victim Cache Buffer

This block is a small fully associative store placed beside a direct-mapped cache. It holds only the blocks that the direct-mapped cache displaces. When the main cache misses, it probes this buffer by full block address. A hit returns the block, so the request never reaches the next level. A miss is passed on to the next level unchanged. Two blocks that fall into the same direct-mapped set and are used in turn therefore stop bouncing through the next level: after the first fill, each access swaps one block back into the cache and parks the other in the buffer.

The main cache presents a displaced block on the eviction port. It may do so alone, or in the same cycle as the lookup that caused the displacement. If the lookup hits and a block is displaced in the same cycle, the displaced block takes the slot of the block that is returned. If there is no lookup hit, the displaced block goes into a free slot. When no slot is free, it replaces the entry that was inserted longest ago, and that entry is written back first if it is dirty. The lookup result and all next-level traffic appear one cycle after the request, from registers.

Top module: `victim_buf`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rsp_valid`, `nl_rd_valid` and `nl_wb_valid` are 0. After reset no entry is valid, so the first lookup misses.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle in which `lookup_valid` was 1.
- R3: On a lookup miss, the response has `rsp_hit`=0. In the same cycle `nl_rd_valid`=1, with `nl_rd_addr` equal to the looked-up address.
- R4: On a lookup hit, the response has `rsp_hit`=1, `rsp_data` and `rsp_dirty` equal to the stored block and its dirty flag, and `nl_rd_valid`=0.
- R5: A lookup hit with no eviction in the same cycle removes the entry, so a repeated lookup of that address misses.
- R6: A lookup hit together with an eviction stores the evicted block in the slot that was hit. No other entry is displaced and no writeback occurs.
- R7: An eviction that finds a free slot causes no writeback.
- R8: An eviction into a full buffer replaces the least recently inserted entry. If that entry is dirty, `nl_wb_valid`=1 in the next cycle, carrying its address and data. The replaced address then misses.
- R9: If the replaced oldest entry is clean, no writeback occurs.
- R10: Two conflicting blocks accessed alternately, each access presenting the other as the evicted block, all hit after the first access, with no next-level read.
- R11: A lookup is compared against the buffer contents as they were before any eviction in the same cycle. A block evicted in that cycle is found by the following lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | A displaced block is presented |
| evict_addr | input | ADDR_W | Block address of the displaced block |
| evict_data | input | BLOCK_W | Data of the displaced block |
| evict_dirty | input | 1 | Displaced block is modified |
| lookup_valid | input | 1 | Probe request |
| lookup_addr | input | ADDR_W | Block address to probe |
| rsp_valid | output | 1 | Probe result is valid |
| rsp_hit | output | 1 | Probe found the block |
| rsp_data | output | BLOCK_W | Returned block (meaningful on hit) |
| rsp_dirty | output | 1 | Returned block is modified |
| nl_rd_valid | output | 1 | Forwarded read to next level |
| nl_rd_addr | output | ADDR_W | Forwarded read address |
| nl_wb_valid | output | 1 | Writeback of a dirty replaced entry |
| nl_wb_addr | output | ADDR_W | Writeback address |
| nl_wb_data | output | BLOCK_W | Writeback data |

## Verification
The bound checker checks the following on every cycle:
- every probe is answered exactly one cycle later;
- a forwarded read appears exactly when a response misses, and it carries the probed address;
- a hit never forwards a read;
- a writeback only follows an eviction.

Some behaviours need state that builds up across many cycles, so only the bench scenarios can show them: the data returned on a hit, that the swap keeps every other entry, the insertion-order choice of victim in a full buffer, the clean or dirty writeback decision, and the ping-pong of two conflicting blocks.

// File: rtl/vcb_pkg.sv
package vcb_pkg;

  // Action applied to the entry array in one cycle
  typedef enum logic [1:0] {
    VOP_NONE = 2'd0,
    VOP_FILL = 2'd1,  // displaced block into free or oldest slot
    VOP_SWAP = 2'd2,  // displaced block into the slot just hit
    VOP_TAKE = 2'd3   // hit entry handed back, slot freed
  } vcb_op_e;

endpackage

// File: rtl/vcb_tag_match.sv
module vcb_tag_match #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 26,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ADDR_W-1:0]              addr,
  output logic                           hit,
  output logic [IDX_W-1:0]               idx
);

  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = valid[g] && (tags[g] == addr);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hit && eq[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/vcb_age_repl.sv
module vcb_age_repl
  import vcb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid,
  input  vcb_op_e            op,
  input  logic [IDX_W-1:0]   slot,
  output logic [IDX_W-1:0]   fill_idx
);

  // Valid entries hold distinct ages 0..n-1, 0 being the newest insertion
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W:0]   ref_age;
  logic             free_found;
  logic [IDX_W-1:0] oldest;

  always_comb begin
    ref_age = valid[slot] ? {1'b0, age_q[slot]} : (IDX_W+1)'(ENTRIES);
  end

  always_comb begin
    free_found = 1'b0;
    fill_idx   = '0;
    oldest     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!free_found && !valid[i]) begin
        free_found = 1'b1;
        fill_idx   = IDX_W'(i);
      end
      if (valid[i] && age_q[i] == IDX_W'(ENTRIES - 1)) oldest = IDX_W'(i);
    end
    if (!free_found) fill_idx = oldest;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= '0;
    end else begin
      case (op)
        VOP_FILL, VOP_SWAP: begin
          for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) == slot)
              age_q[i] <= '0;
            else if (valid[i] && ({1'b0, age_q[i]} < ref_age))
              age_q[i] <= age_q[i] + 1'b1;
          end
        end
        VOP_TAKE: begin
          for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) != slot && valid[i] && age_q[i] > age_q[slot])
              age_q[i] <= age_q[i] - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vcb_store.sv
module vcb_store #(
  parameter int ENTRIES = 8,
  parameter int BLOCK_W = 512,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [BLOCK_W-1:0] wdata,
  input  logic [IDX_W-1:0]   raddr_a,
  output logic [BLOCK_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]   raddr_b,
  output logic [BLOCK_W-1:0] rdata_b
);

  // Block data, no reset so it maps onto block RAM; reads return old data
  logic [BLOCK_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata_a <= mem[raddr_a];
  end

  always_ff @(posedge clk) begin
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/victim_buf.sv
module victim_buf
  import vcb_pkg::*;
#(
  parameter int ENTRIES     = 8,
  parameter int ADDR_W      = 26,
  parameter int BLOCK_BYTES = 64,
  parameter int BLOCK_W     = BLOCK_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evict_valid,
  input  logic [ADDR_W-1:0]  evict_addr,
  input  logic [BLOCK_W-1:0] evict_data,
  input  logic               evict_dirty,
  input  logic               lookup_valid,
  input  logic [ADDR_W-1:0]  lookup_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [BLOCK_W-1:0] rsp_data,
  output logic               rsp_dirty,
  output logic               nl_rd_valid,
  output logic [ADDR_W-1:0]  nl_rd_addr,
  output logic               nl_wb_valid,
  output logic [ADDR_W-1:0]  nl_wb_addr,
  output logic [BLOCK_W-1:0] nl_wb_data
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0]             vld_q;
  logic [ENTRIES-1:0]             dty_q;

  logic             match;
  logic [IDX_W-1:0] hit_idx;
  logic             lk_hit;
  logic [IDX_W-1:0] fill_idx;
  logic [IDX_W-1:0] slot;
  vcb_op_e          op;
  logic             wb_need;

  vcb_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .tags  (tag_q),
    .valid (vld_q),
    .addr  (lookup_addr),
    .hit   (match),
    .idx   (hit_idx)
  );

  assign lk_hit = lookup_valid && match;

  // Decide what the eviction / lookup pair does to the entry array
  always_comb begin
    op   = VOP_NONE;
    slot = fill_idx;
    if (evict_valid && lk_hit) begin
      op   = VOP_SWAP;
      slot = hit_idx;
    end else if (evict_valid) begin
      op   = VOP_FILL;
      slot = fill_idx;
    end else if (lk_hit) begin
      op   = VOP_TAKE;
      slot = hit_idx;
    end
  end

  assign wb_need = (op == VOP_FILL) && vld_q[slot] && dty_q[slot];

  vcb_age_repl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_age (
    .clk      (clk),
    .rst      (rst),
    .valid    (vld_q),
    .op       (op),
    .slot     (slot),
    .fill_idx (fill_idx)
  );

  vcb_store #(.ENTRIES(ENTRIES), .BLOCK_W(BLOCK_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .we      (evict_valid),
    .waddr   (slot),
    .wdata   (evict_data),
    .raddr_a (hit_idx),
    .rdata_a (rsp_data),
    .raddr_b (fill_idx),
    .rdata_b (nl_wb_data)
  );

  // Entry metadata
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      dty_q <= '0;
      tag_q <= '0;
    end else begin
      case (op)
        VOP_FILL, VOP_SWAP: begin
          tag_q[slot] <= evict_addr;
          vld_q[slot] <= 1'b1;
          dty_q[slot] <= evict_dirty;
        end
        VOP_TAKE: vld_q[slot] <= 1'b0;
        default: ;
      endcase
    end
  end

  // Registered response and next-level requests
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_dirty   <= 1'b0;
      nl_rd_valid <= 1'b0;
      nl_rd_addr  <= '0;
      nl_wb_valid <= 1'b0;
      nl_wb_addr  <= '0;
    end else begin
      rsp_valid   <= lookup_valid;
      rsp_hit     <= lk_hit;
      rsp_dirty   <= lk_hit && dty_q[hit_idx];
      nl_rd_valid <= lookup_valid && !match;
      nl_rd_addr  <= lookup_addr;
      nl_wb_valid <= wb_need;
      nl_wb_addr  <= tag_q[slot];
    end
  end

endmodule

// File: rtl/victim_buf_chk.sv
module victim_buf_chk #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst,
  input logic              evict_valid,
  input logic              lookup_valid,
  input logic [ADDR_W-1:0] lookup_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              nl_rd_valid,
  input logic [ADDR_W-1:0] nl_rd_addr,
  input logic              nl_wb_valid
);

  // R2
  rsp_follows_lookup_chk: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !lookup_valid |=> !rsp_valid);

  // R3
  miss_forwards_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> nl_rd_valid);

  // R3
  fwd_only_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
    nl_rd_valid |-> (rsp_valid && !rsp_hit));

  // R3
  fwd_addr_chk: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> (!nl_rd_valid || nl_rd_addr == $past(lookup_addr)));

  // R4
  hit_no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_valid && !nl_rd_valid));

  // R8
  wb_after_evict_chk: assert property (@(posedge clk) disable iff (rst)
    !evict_valid |=> !nl_wb_valid);

endmodule

bind victim_buf victim_buf_chk #(.ADDR_W(ADDR_W)) u_victim_buf_chk (
  .clk          (clk),
  .rst          (rst),
  .evict_valid  (evict_valid),
  .lookup_valid (lookup_valid),
  .lookup_addr  (lookup_addr),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .nl_rd_valid  (nl_rd_valid),
  .nl_rd_addr   (nl_rd_addr),
  .nl_wb_valid  (nl_wb_valid)
);

// File: tb/victim_buf_bench.sv
`timescale 1ns/1ps
module victim_buf_bench;
  localparam int ENTRIES = 8;
  localparam int ADDR_W  = 26;
  localparam int BLOCK_W = 512;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               evict_valid = 1'b0;
  logic [ADDR_W-1:0]  evict_addr = '0;
  logic [BLOCK_W-1:0] evict_data = '0;
  logic               evict_dirty = 1'b0;
  logic               lookup_valid = 1'b0;
  logic [ADDR_W-1:0]  lookup_addr = '0;
  logic               rsp_valid, rsp_hit, rsp_dirty;
  logic [BLOCK_W-1:0] rsp_data, nl_wb_data;
  logic               nl_rd_valid, nl_wb_valid;
  logic [ADDR_W-1:0]  nl_rd_addr, nl_wb_addr;

  always #4 clk = ~clk;

  victim_buf #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_W/8)) u_victim_buf (
    .clk(clk), .rst(rst),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .evict_data(evict_data), .evict_dirty(evict_dirty),
    .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
    .nl_rd_valid(nl_rd_valid), .nl_rd_addr(nl_rd_addr),
    .nl_wb_valid(nl_wb_valid), .nl_wb_addr(nl_wb_addr), .nl_wb_data(nl_wb_data)
  );

  typedef struct {
    bit                 rv;
    bit                 hit;
    logic [BLOCK_W-1:0] data;
    bit                 dirty;
    bit                 rdv;
    logic [ADDR_W-1:0]  rda;
    bit                 wbv;
    logic [ADDR_W-1:0]  wba;
    logic [BLOCK_W-1:0] wbd;
    string              req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  function automatic logic [BLOCK_W-1:0] blk(input logic [ADDR_W-1:0] a);
    return {16{32'(a) ^ 32'h5A3C_0000}};
  endfunction

  function automatic exp_t e_idle(input string r);
    exp_t e;
    e.rv = 0; e.hit = 0; e.data = '0; e.dirty = 0;
    e.rdv = 0; e.rda = '0; e.wbv = 0; e.wba = '0; e.wbd = '0; e.req = r;
    return e;
  endfunction

  function automatic exp_t e_miss(input logic [ADDR_W-1:0] a, input string r);
    exp_t e = e_idle(r);
    e.rv = 1; e.rdv = 1; e.rda = a;
    return e;
  endfunction

  function automatic exp_t e_hit(input logic [ADDR_W-1:0] a, input bit d, input string r);
    exp_t e = e_idle(r);
    e.rv = 1; e.hit = 1; e.data = blk(a); e.dirty = d;
    return e;
  endfunction

  function automatic exp_t e_wb(input logic [ADDR_W-1:0] a, input string r);
    exp_t e = e_idle(r);
    e.wbv = 1; e.wba = a; e.wbd = blk(a);
    return e;
  endfunction

  // Driver: one cycle of stimulus plus its expected result
  task automatic step(input bit lk, input logic [ADDR_W-1:0] la,
                      input bit ev, input logic [ADDR_W-1:0] ea, input bit ed,
                      input exp_t e);
    @(negedge clk);
    lookup_valid = lk;
    lookup_addr  = la;
    evict_valid  = ev;
    evict_addr   = ea;
    evict_data   = blk(ea);
    evict_dirty  = ed;
    q.push_back(e);
  endtask

  // Monitor: compare after the edge that consumed the stimulus
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      bit bad;
      e = q.pop_front();
      bad = (rsp_valid !== e.rv) || (rsp_valid && rsp_hit !== e.hit) ||
            (e.hit && (rsp_data !== e.data || rsp_dirty !== e.dirty)) ||
            (nl_rd_valid !== e.rdv) || (e.rdv && nl_rd_addr !== e.rda) ||
            (nl_wb_valid !== e.wbv) ||
            (e.wbv && (nl_wb_addr !== e.wba || nl_wb_data !== e.wbd));
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL %s: got rv=%0b hit=%0b d=%h dty=%0b rd=%0b/%h wb=%0b/%h/%h exp rv=%0b hit=%0b d=%h dty=%0b rd=%0b/%h wb=%0b/%h/%h",
                 e.req, rsp_valid, rsp_hit, rsp_data[31:0], rsp_dirty, nl_rd_valid, nl_rd_addr,
                 nl_wb_valid, nl_wb_addr, nl_wb_data[31:0],
                 e.rv, e.hit, e.data[31:0], e.dirty, e.rdv, e.rda, e.wbv, e.wba, e.wbd[31:0]);
      end
    end
  end

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: got hung run, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  localparam logic [ADDR_W-1:0] A_ADDR = 26'h000100;
  localparam logic [ADDR_W-1:0] X_ADDR = 26'h000040;
  localparam logic [ADDR_W-1:0] Y_ADDR = 26'h000440;
  localparam logic [ADDR_W-1:0] B_BASE = 26'h000200;
  localparam logic [ADDR_W-1:0] C_BASE = 26'h000300;
  localparam logic [ADDR_W-1:0] D_ADDR = 26'h000500;
  localparam logic [ADDR_W-1:0] F_ADDR = 26'h000600;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || nl_rd_valid !== 1'b0 || nl_wb_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: got rv=%0b rd=%0b wb=%0b exp 0 0 0 in reset", rsp_valid, nl_rd_valid, nl_wb_valid);
    end
    rst = 1'b0;
    step(0, '0, 0, '0, 0, e_idle("R1 R2 idle after reset"));
    step(1, A_ADDR, 0, '0, 0, e_miss(A_ADDR, "R1 R3 first lookup"));
    // Ping-pong of two conflicting blocks
    step(1, Y_ADDR, 1, X_ADDR, 0, e_miss(Y_ADDR, "R3 R10 first fill"));
    step(1, X_ADDR, 1, Y_ADDR, 1, e_hit(X_ADDR, 0, "R10 R6 swap X"));
    step(1, Y_ADDR, 1, X_ADDR, 0, e_hit(Y_ADDR, 1, "R10 swap Y"));
    step(1, X_ADDR, 1, Y_ADDR, 1, e_hit(X_ADDR, 0, "R10 swap X"));
    step(1, Y_ADDR, 1, X_ADDR, 0, e_hit(Y_ADDR, 1, "R10 swap Y"));
    // Take without eviction frees the entry
    step(1, X_ADDR, 0, '0, 0, e_hit(X_ADDR, 0, "R5 take"));
    step(1, X_ADDR, 0, '0, 0, e_miss(X_ADDR, "R5 gone"));
    // Fill all slots, odd ones dirty
    for (int i = 0; i < ENTRIES; i++)
      step(0, '0, 1, B_BASE + ADDR_W'(i), i[0], e_idle("R7 fill free slot"));
    step(1, B_BASE + 26'd3, 0, '0, 0, e_hit(B_BASE + 26'd3, 1, "R4 hit data"));
    step(0, '0, 1, C_BASE, 0, e_idle("R7 refill freed slot"));
    step(0, '0, 1, C_BASE + 26'd1, 0, e_idle("R9 clean oldest"));
    step(0, '0, 1, C_BASE + 26'd2, 0, e_wb(B_BASE + 26'd1, "R8 dirty oldest"));
    step(0, '0, 1, C_BASE + 26'd3, 0, e_idle("R9 clean oldest"));
    step(0, '0, 1, C_BASE + 26'd4, 0, e_idle("R9 clean oldest"));
    step(0, '0, 1, C_BASE + 26'd5, 0, e_wb(B_BASE + 26'd5, "R8 dirty oldest"));
    step(1, B_BASE, 0, '0, 0, e_miss(B_BASE, "R8 replaced misses"));
    step(1, B_BASE + 26'd6, 0, '0, 0, e_hit(B_BASE + 26'd6, 0, "R4 clean hit"));
    step(1, B_BASE + 26'd7, 1, D_ADDR, 1, e_hit(B_BASE + 26'd7, 1, "R6 swap no wb"));
    step(1, C_BASE, 0, '0, 0, e_hit(C_BASE, 0, "R6 others kept"));
    step(1, F_ADDR, 1, F_ADDR, 1, e_miss(F_ADDR, "R11 same-cycle evict"));
    step(1, F_ADDR, 0, '0, 0, e_hit(F_ADDR, 1, "R11 found next"));
    step(1, D_ADDR, 0, '0, 0, e_hit(D_ADDR, 1, "R6 swapped in"));
    step(0, '0, 0, '0, 0, e_idle("R2 idle"));
    step(0, '0, 0, '0, 0, e_idle("R2 idle"));
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule